// File: doc/BRIEF.md
# Planar Read Path with Colour Compare

This block forms the read side of a four-plane graphics memory controller. When the CPU reads one address, the memory returns one byte from each plane at that address. The block captures all of those bytes into a bank of read latches. The write path uses these latches later for copies and logic operations. In the same cycle the block returns a single byte to the CPU.

The returned byte comes from one of two read modes. In plane-select mode the CPU gets the raw byte of one plane, chosen by a small select field. In colour-compare mode each of the eight pixels in the byte is treated as a colour. That colour is built from the same bit position of every plane. The CPU gets a vector with one bit set per pixel whose colour equals a programmed compare colour. A per-plane mask can drop planes from that comparison.

Top module: `plane_read_unit`

## Requirements
- R1: After a synchronous active-low reset, `rd_data`, `latch_bytes` and `rd_valid` are all zero.
- R2: With `rd_mode` = 0, a read strobe in cycle k makes `rd_data` equal, from cycle k+1, the byte of plane `map_sel` (plane p occupies bits [8p+7:8p] of `plane_bytes`).
- R3: With `rd_mode` = 1, bit i of `rd_data` after a read is 1 exactly when bit i of plane p equals bit p of `cmp_color` for every plane p whose bit p of `dont_care` is 1.
- R4: A plane whose `dont_care` bit is 0 has no effect on the compare result. With `dont_care` = 0 the result is 0xFF.
- R5: Every read strobe loads all plane bytes into `latch_bytes` one cycle later, in either read mode.
- R6: While `rd_stb` is low, `rd_data` and `latch_bytes` hold their values whatever the other inputs do.
- R7: `rd_valid` is high in exactly the cycle after each cycle in which `rd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | CPU read strobe, one cycle per read |
| plane_bytes | input | 32 | Addressed byte of each plane, plane 0 in the low byte |
| rd_mode | input | 1 | 0 = plane select, 1 = colour compare |
| map_sel | input | 2 | Plane returned in plane-select mode |
| cmp_color | input | 4 | Compare colour, bit p for plane p |
| dont_care | input | 4 | Plane participation mask, 1 = plane compared |
| rd_data | output | 8 | Byte returned to the CPU |
| latch_bytes | output | 32 | Read latches, same layout as `plane_bytes` |
| rd_valid | output | 1 | `rd_data` and latches were updated by the last cycle's read |

## Verification
The bench builds the block with its default four planes of eight pixels. At this size, sweeping every compare colour against every participation mask is cheap. Two plane patterns are crafted so that the eight pixels carry all sixteen colours between them, so every colour/mask pair meets both matching and non-matching pixels. Plane-select reads cover all four selects over several arithmetic patterns, and idle cycles with changing inputs confirm that the outputs hold.

// File: rtl/plane_read_pkg.sv
// Shared types for the planar read path.
package plane_read_pkg;
    typedef enum logic {
        RD_PLANE = 1'b0,
        RD_MATCH = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/prd_latch_bank.sv
// Read latch bank: captures every plane byte on a read strobe.
// Assumes the plane bytes are valid in the strobe cycle.
module prd_latch_bank #(
    parameter int NUM_PLANES = 4,
    parameter int PIX_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM_PLANES*PIX_W-1:0] din,
    output logic [NUM_PLANES*PIX_W-1:0] q
);
    // Load all planes on a read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(din));
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/prd_plane_mux.sv
// Plane selector: returns the byte of the plane named by sel.
// Assumes NUM_PLANES is a power of two so that every sel value is legal.
module prd_plane_mux #(
    parameter int NUM_PLANES = 4,
    parameter int PIX_W      = 8,
    localparam int SEL_W     = $clog2(NUM_PLANES)
) (
    input  logic [NUM_PLANES*PIX_W-1:0] planes,
    input  logic [SEL_W-1:0]            sel,
    output logic [PIX_W-1:0]            dout
);
    logic [PIX_W-1:0] plane_arr [NUM_PLANES];

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_split
        assign plane_arr[g] = planes[g*PIX_W +: PIX_W];
    end

    assign dout = plane_arr[sel];
endmodule

// File: rtl/prd_color_match.sv
// Colour comparator: one match bit per pixel. A pixel matches when every
// participating plane bit equals the corresponding compare colour bit.
// Planes with a clear mask bit never cause a miss.
module prd_color_match #(
    parameter int NUM_PLANES = 4,
    parameter int PIX_W      = 8
) (
    input  logic [NUM_PLANES*PIX_W-1:0] planes,
    input  logic [NUM_PLANES-1:0]       color,
    input  logic [NUM_PLANES-1:0]       mask,
    output logic [PIX_W-1:0]            match
);
    for (genvar px = 0; px < PIX_W; px++) begin : g_pix
        logic miss;
        // Accumulate mismatches over the participating planes of one pixel.
        always_comb begin
            miss = 1'b0;
            for (int p = 0; p < NUM_PLANES; p++) begin
                miss = miss | ((planes[p*PIX_W+px] ^ color[p]) & mask[p]);
            end
        end
        assign match[px] = ~miss;
    end

    always_comb begin
        a_r4_no_plane_all_match: assert (mask != '0 || match == '1);
    end
endmodule

// File: rtl/plane_read_unit.sv
// Planar read path top. On a read strobe it latches all plane bytes and
// registers either the selected plane or the colour-compare vector.
// Assumes one strobe per read with the plane bytes valid in that cycle.
module plane_read_unit
    import plane_read_pkg::*;
#(
    parameter int NUM_PLANES = 4,
    parameter int PIX_W      = 8,
    localparam int SEL_W     = $clog2(NUM_PLANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_stb,
    input  logic [NUM_PLANES*PIX_W-1:0] plane_bytes,
    input  logic                        rd_mode,
    input  logic [SEL_W-1:0]            map_sel,
    input  logic [NUM_PLANES-1:0]       cmp_color,
    input  logic [NUM_PLANES-1:0]       dont_care,
    output logic [PIX_W-1:0]            rd_data,
    output logic [NUM_PLANES*PIX_W-1:0] latch_bytes,
    output logic                        rd_valid
);
    logic [PIX_W-1:0] sel_byte;
    logic [PIX_W-1:0] match_vec;

    prd_latch_bank #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(rd_stb),
        .din(plane_bytes), .q(latch_bytes)
    );

    prd_plane_mux #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_mux (
        .planes(plane_bytes), .sel(map_sel), .dout(sel_byte)
    );

    prd_color_match #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_match (
        .planes(plane_bytes), .color(cmp_color), .mask(dont_care),
        .match(match_vec)
    );

    // Register the CPU result for the active read mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= (rd_mode_e'(rd_mode) == RD_MATCH) ? match_vec : sel_byte;
    end

    // Flag the cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_stb;
    end

    a_r2_plane_select: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !rd_mode |=> rd_data == $past(sel_byte));
    a_r3_compare_path: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_mode |=> rd_data == $past(match_vec));
    a_r4_all_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_mode && dont_care == '0 |=> rd_data == '1);
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);
endmodule

// File: tb/plane_read_unit_tb.sv
module plane_read_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_stb;
    logic [31:0] plane_bytes;
    logic        rd_mode;
    logic [1:0]  map_sel;
    logic [3:0]  cmp_color;
    logic [3:0]  dont_care;
    logic [7:0]  rd_data;
    logic [31:0] latch_bytes;
    logic        rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    plane_read_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .plane_bytes(plane_bytes),
        .rd_mode(rd_mode), .map_sel(map_sel), .cmp_color(cmp_color),
        .dont_care(dont_care), .rd_data(rd_data), .latch_bytes(latch_bytes),
        .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_match(input logic [31:0] pl, input logic [3:0] cc,
                                             input logic [3:0] dc);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic ok;
            ok = 1'b1;
            for (int p = 0; p < 4; p++)
                if (dc[p] && (pl[p*8+i] != cc[p])) ok = 1'b0;
            r[i] = ok;
        end
        return r;
    endfunction

    // One read: drive on the falling edge, check one cycle after the strobe.
    task automatic do_read(input logic [31:0] pl, input logic md, input logic [1:0] ms,
                           input logic [3:0] cc, input logic [3:0] dc,
                           input logic [7:0] exp, input string req);
        @(negedge clk);
        plane_bytes = pl; rd_mode = md; map_sel = ms; cmp_color = cc; dont_care = dc;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, {24'd0, rd_data}, {24'd0, exp});
        check("R5", latch_bytes, pl);
        check("R7", {31'd0, rd_valid}, 32'd1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pl;
        rst_n = 1'b0; rd_stb = 1'b0; plane_bytes = 32'hDEADBEEF;
        rd_mode = 1'b0; map_sel = 2'd0; cmp_color = 4'd0; dont_care = 4'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {24'd0, rd_data}, 32'd0);
        check("R1", latch_bytes, 32'd0);
        check("R1", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;

        // R2: plane select over all selects and several patterns
        for (int s = 0; s < 6; s++) begin
            for (int p = 0; p < 4; p++) begin
                pl[p*8 +: 8] = 8'((s*53 + p*29 + 7) & 255);
            end
            for (int m = 0; m < 4; m++)
                do_read(pl, 1'b0, 2'(m), 4'(s), 4'(15 - s), pl[m*8 +: 8], "R2");
        end

        // R3/R4: every colour against every mask over four patterns
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: pl = {8'h00, 8'hF0, 8'hCC, 8'hAA};
                1: pl = {8'hFF, 8'hF0, 8'hCC, 8'hAA};
                2: pl = {8'h5A, 8'h3C, 8'hE1, 8'h96};
                default: pl = 32'h0F1E_2D3C;
            endcase
            for (int cc = 0; cc < 16; cc++)
                for (int dc = 0; dc < 16; dc++)
                    do_read(pl, 1'b1, 2'(cc), 4'(cc), 4'(dc), exp_match(pl, 4'(cc), 4'(dc)),
                            (dc == 0) ? "R4" : "R3");
        end

        // R4: an excluded plane flipped does not change the result
        do_read(32'h00F0_CCAA, 1'b1, 2'd0, 4'b0101, 4'b0101, exp_match(32'h00F0_CCAA, 4'b0101, 4'b0101), "R4");
        do_read(32'h55F0_33AA, 1'b1, 2'd0, 4'b0101, 4'b0101, exp_match(32'h00F0_CCAA, 4'b0101, 4'b0101), "R4");

        // R6: idle cycles with changing inputs leave outputs alone
        do_read(32'h1234_5678, 1'b0, 2'd2, 4'd0, 4'd0, 8'h34, "R2");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            plane_bytes = 32'hA5A5_0000 + 32'(i * 4097);
            rd_mode = 1'(i); map_sel = 2'(i); cmp_color = 4'(i); dont_care = 4'(~i);
            @(negedge clk);
            check("R6", {24'd0, rd_data}, 32'h34);
            check("R6", latch_bytes, 32'h1234_5678);
            check("R7", {31'd0, rd_valid}, 32'd0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule